// File: doc/BRIEF.md
# Counter-Compare Gray-Level Window Generator

This block turns a set of stored per-channel gray levels into per-channel sampling windows. An external analog ramp is gated onto each channel's hold capacitor while that channel's window is open. The window closes when a shared step counter reaches the channel's level, so the held voltage tracks the level. Each code is 7 bits wide, which gives 128 distinct levels. With the default parameters there are 32 channels.

A load pulse does two jobs. Its rising edge copies the parallel input codes into per-channel comparator registers. Its falling edge starts a conversion. At that start, a one-cycle clear strobe tells the output stage to discharge, the shared counter returns to zero, and every window opens.

Each rising edge of the count clock then does two things. First, it closes every window whose stored code equals the counter's present value. Second, it advances the counter, which stops at 127. Both the load pulse and the count clock are level inputs. They are sampled and edge-detected in the system clock domain.

The control state machine has three states:
- IDLE: no conversion is in progress.
- HOLD: codes have been captured and the load pulse is still high.
- RUN: the block is counting.

Its transitions are:
- capture: IDLE or RUN goes to HOLD on a load rising edge. A rising edge during RUN aborts the conversion and freezes the windows.
- start: HOLD goes to RUN on a load falling edge.
- finish: RUN goes to IDLE on the count edge taken while the counter is at 127.

Top module: `gray_ramp_sampler`

## Requirements
- R1: After reset, all windows are 0, busy is 0 and the clear strobe is 0.
- R2: A load rising edge captures `data_in` into the stored codes. Channel i's code is `data_in[7*i+6:7*i]`. Changes to `data_in` after that edge, including changes before the falling edge, do not alter the stored codes.
- R3: One cycle after a load falling edge in HOLD, every window is 1, `clr_out` is 1 for exactly one cycle, and the counter is 0.
- R4: During RUN, channel i's window goes to 0 on count edge number code_i+1 and stays 0 afterwards. The edges are counted from 1 after the start.
- R5: A channel with code 0 closes on the first count edge.
- R6: The counter saturates at 127. A channel with code 127 closes on the 128th count edge.
- R7: `busy` is 1 from the load rising edge until the 128th count edge, and 0 one cycle after that edge. Whenever `busy` is 0, all windows are 0.
- R8: Count-clock edges in IDLE or HOLD change neither the windows nor busy. The next conversion still counts from 0.
- R9: `data_in` changes during RUN do not affect when any window closes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_cnt | input | 1 | Load pulse: rising edge captures codes, falling edge starts a conversion |
| cnt_clk | input | 1 | Count clock; each rising edge is one counter step |
| data_in | input | NCH*W | Packed input codes, channel i at bits [W*i+W-1:W*i] |
| win | output | NCH | Per-channel sampling window |
| clr_out | output | 1 | One-cycle strobe at the start of a conversion |
| busy | output | 1 | High from capture until the last window closes |

## Verification
The hardest case to reach is the end of a conversion. It takes 128 count edges, and only a code of 127 keeps a window open that long. That is the moment when saturation, the last window close and busy dropping all happen together. The bench fills the channels with a spread of codes that includes 0 and 127. It then drives a full 128-edge run and compares every window after every edge against the model "open while code ≥ edge count". It also drives extra edges after the finish and during HOLD, to show that these edges are ignored.

// File: rtl/gray_ramp_pkg.sv
package gray_ramp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_RUN  = 2'd2
    } conv_state_t;
endpackage

// File: rtl/grs_edge_detect.sv
module grs_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic rise,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig_in;
    end

    assign rise = sig_in & ~prev_q;
    assign fall = ~sig_in & prev_q;
endmodule

// File: rtl/grs_step_counter.sv
module grs_step_counter #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    count <= '0;
        else if (clr)                  count <= '0;
        else if (inc && count != MAXV) count <= count + 1'b1;
    end

    // R6: counter holds at its top value
    a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(inc) && !$past(clr) && $past(count) == MAXV) |-> count == MAXV);
    // R3: a clear returns the counter to zero
    a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) |-> count == '0);
endmodule

// File: rtl/grs_channel.sv
module grs_channel #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture,
    input  logic         start,
    input  logic         step,
    input  logic [W-1:0] din,
    input  logic [W-1:0] count,
    output logic         win
);
    logic [W-1:0] code_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       code_q <= '0;
        else if (capture) code_q <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         win <= 1'b0;
        else if (start)                     win <= 1'b1;
        else if (step && count == code_q)   win <= 1'b0;
    end

    // R2: stored code changes only on a capture
    a_r2_code_held: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(capture) |-> code_q == $past(code_q));
    // R3: a start opens the window
    a_r3_open_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start) |-> win);
    // R4: a window closes only on a step that matches its code
    a_r4_close_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(win) |-> ($past(step) && $past(count) == $past(code_q)));
endmodule

// File: rtl/gray_ramp_sampler.sv
module gray_ramp_sampler
    import gray_ramp_pkg::*;
#(
    parameter int NCH = 32,
    parameter int W   = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_cnt,
    input  logic           cnt_clk,
    input  logic [NCH*W-1:0] data_in,
    output logic [NCH-1:0] win,
    output logic           clr_out,
    output logic           busy
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    conv_state_t state_q, state_n;
    logic ld_rise, ld_fall, cc_rise, cc_fall_unused;
    logic ld_fall_unused;
    logic capture, start, step;
    logic [W-1:0] count;

    grs_edge_detect u_ld_edge (
        .clk(clk), .rst_n(rst_n), .sig_in(load_cnt),
        .rise(ld_rise), .fall(ld_fall)
    );
    grs_edge_detect u_cc_edge (
        .clk(clk), .rst_n(rst_n), .sig_in(cnt_clk),
        .rise(cc_rise), .fall(cc_fall_unused)
    );
    assign ld_fall_unused = cc_fall_unused;

    assign capture = ld_rise;
    assign start   = ld_fall && (state_q == ST_HOLD);
    assign step    = cc_rise && (state_q == ST_RUN) && !ld_rise;

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: if (ld_rise) state_n = ST_HOLD;
            ST_HOLD: if (ld_fall) state_n = ST_RUN;
            ST_RUN: begin
                if (ld_rise)                        state_n = ST_HOLD;
                else if (step && count == MAXV)     state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            clr_out <= 1'b0;
        end else begin
            busy    <= (state_n != ST_IDLE);
            clr_out <= start;
        end
    end

    grs_step_counter #(.W(W)) u_counter (
        .clk(clk), .rst_n(rst_n), .clr(start), .inc(step), .count(count)
    );

    for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
        grs_channel #(.W(W)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .capture(capture), .start(start), .step(step),
            .din(data_in[gi*W +: W]), .count(count),
            .win(win[gi])
        );
    end

    // R3: the clear strobe comes with every window open
    a_r3_clr_opens: assert property (@(posedge clk) disable iff (!rst_n)
        clr_out |-> (&win));
    // R3: the clear strobe lasts one cycle
    a_r3_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
        clr_out |=> !clr_out);
    // R7: when idle, no window is open
    a_r7_idle_closed: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (win == '0));
    // R8: windows never open outside a start
    a_r8_open_only_start: assert property (@(posedge clk) disable iff (!rst_n)
        (win & ~$past(win)) != '0 |-> $past(start));
endmodule

// File: tb/gray_ramp_sampler_test.sv
module gray_ramp_sampler_test;
    localparam int NCH = 32;
    localparam int W   = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load_cnt = 1'b0;
    logic cnt_clk = 1'b0;
    logic [NCH*W-1:0] data_in = '0;
    logic [NCH-1:0] win;
    logic clr_out, busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [W-1:0] codes [NCH];

    always #10 clk = ~clk;

    gray_ramp_sampler #(.NCH(NCH), .W(W)) uut (
        .clk(clk), .rst_n(rst_n), .load_cnt(load_cnt), .cnt_clk(cnt_clk),
        .data_in(data_in), .win(win), .clr_out(clr_out), .busy(busy)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    function automatic logic [NCH*W-1:0] pack_codes(input int seed);
        logic [NCH*W-1:0] v;
        for (int i = 0; i < NCH; i++) v[i*W +: W] = W'((i * 37 + seed) % 128);
        return v;
    endfunction

    task automatic set_codes(input int seed, input bit ends);
        data_in = pack_codes(seed);
        if (ends) begin
            data_in[0 +: W] = '0;
            data_in[(NCH-1)*W +: W] = 7'd127;
        end
        for (int i = 0; i < NCH; i++) codes[i] = data_in[i*W +: W];
    endtask

    function automatic logic [NCH-1:0] exp_win(input int k);
        logic [NCH-1:0] e;
        for (int i = 0; i < NCH; i++) e[i] = (int'(codes[i]) >= k);
        return e;
    endfunction

    task automatic count_pulse();
        cnt_clk = 1'b1;
        cyc(1);
        cnt_clk = 1'b0;
        cyc(1);
    endtask

    task automatic load_rise();
        load_cnt = 1'b1;
        cyc(2);
        chk("R7 busy after capture", 64'(busy), 64'd1);
    endtask

    task automatic load_fall();
        load_cnt = 1'b0;
        cyc(1);
        chk("R3 clear strobe", 64'(clr_out), 64'd1);
        chk("R3 all windows open", 64'(win), 64'({NCH{1'b1}}));
        cyc(1);
        chk("R3 strobe single cycle", 64'(clr_out), 64'd0);
    endtask

    task automatic run_all(input string req, input bit scramble);
        for (int k = 1; k <= 128; k++) begin
            if (scramble) data_in = pack_codes(k * 11);
            count_pulse();
            chk(req, 64'(win), 64'(exp_win(k)));
            if (k == 1) chk("R5 code 0 closes first edge", 64'(win[0]), 64'd0);
            if (k == 127) chk("R6 code 127 open at edge 127", 64'(win[NCH-1]), 64'd1);
            chk("R7 busy during run", 64'(busy), 64'(k < 128));
        end
        chk("R6 code 127 closed at edge 128", 64'(win[NCH-1]), 64'd0);
    endtask

    task automatic t_reset();
        chk("R1 windows at reset", 64'(win), 64'd0);
        chk("R1 busy at reset", 64'(busy), 64'd0);
        chk("R1 strobe at reset", 64'(clr_out), 64'd0);
    endtask

    task automatic t_basic();
        set_codes(3, 1'b1);
        load_rise();
        data_in = pack_codes(91);
        cyc(1);
        load_fall();
        run_all("R2 R4 captured codes close in order", 1'b0);
    endtask

    task automatic t_ignored_edges();
        count_pulse();
        count_pulse();
        chk("R8 idle edges keep windows", 64'(win), 64'd0);
        chk("R8 idle edges keep busy", 64'(busy), 64'd0);
        set_codes(50, 1'b1);
        load_rise();
        for (int j = 0; j < 3; j++) count_pulse();
        chk("R8 hold edges keep windows", 64'(win), 64'd0);
        chk("R8 hold edges keep busy", 64'(busy), 64'd1);
        load_fall();
        run_all("R8 R4 counting restarts from zero", 1'b0);
    endtask

    task automatic t_data_change();
        set_codes(17, 1'b1);
        for (int i = 1; i < NCH - 1; i++) begin
            data_in[i*W +: W] = 7'd64;
            codes[i] = 7'd64;
        end
        load_rise();
        load_fall();
        run_all("R9 data changes during run ignored", 1'b1);
    endtask

    initial begin
        cyc(3);
        t_reset();
        rst_n = 1'b1;
        cyc(2);
        t_basic();
        t_ignored_edges();
        t_data_change();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule